// File: doc/BRIEF.md
# Multi-Source Clock Frequency Counter

This block estimates the rate of one of four selectable clocks by counting its rising edges during a window. The window length is given in cycles of a fixed reference clock, which is nominally 108 MHz (four times a 27 MHz crystal). The same reference clock runs the register interface. Software sets up a measurement through one control word:

1. Write the clear bit.
2. Poll until the count word reads zero.
3. Write a start word with the run bit set and the field-update bit set, which loads the source index and the window length.
4. Wait for the done flag, then read the raw edge count.

The raw count is not converted into a frequency here. One of the sources is a divided clock, and software scales its count by two.

The window timer lives in the reference domain. A counting gate crosses into the selected clock's domain through a two-flop synchronizer. The clear request crosses the same way and returns as an acknowledge. When the gate closes, the measured domain freezes its counter and raises a finish flag. The reference domain synchronizes that flag and then copies the frozen count, so the count bus itself never has to be synchronized. The edge counter saturates rather than wrapping.

Top module: `freq_counter`

## Requirements
- R1: After reset, both read addresses return zero and `done_o` is low.
- R2: A write with bit 0 (clear) set drops `done_o` in the following cycle, and the count word reads zero within 40 reference cycles after that write.
- R3: A write with bit 2 (field update) clear leaves the window and source fields unchanged. Bits 0 (clear) and 1 (run) still take the written values.
- R4: A start write (bit 1 set, bit 0 clear) taken while idle gates counting for the number of reference cycles in bits [31:16]. The captured count lies within 2 of window × f_src / f_ref.
- R5: Bits [4:3], loaded on a write with bit 2 set, select which `src_clk_i[n]` is counted.
- R6: A window field below `MIN_WIN` is counted as `MIN_WIN` reference cycles. This includes zero.
- R7: When the window has closed and the count has been captured, `done_o` and control bit 8 go high. The count then holds, and further start writes are ignored until the next clear.
- R8: The edge count saturates at 2^`CNT_W` − 1 instead of wrapping.
- R9: `raddr_i` = 0 returns the control word: bit 0 clear, bit 1 run, bit 2 reads zero, [4:3] source, bit 8 done, [31:16] window. `raddr_i` = 1 returns the count, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk_i | input | 1 | Reference clock; also clocks the register interface |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_clk_i | input | SRC_N | Candidate clocks to be measured |
| wr_i | input | 1 | Control-word write strobe |
| wdata_i | input | 32 | Control-word write data |
| raddr_i | input | 1 | Read select: 0 control, 1 count |
| rdata_o | output | 32 | Read data |
| done_o | output | 1 | Result captured and stable |

## Verification
The assertions assume two things about the source clock:
- The source index changes only while no window is open.
- The selected clock runs fast enough to sample a gate pulse of `MIN_WIN` reference cycles.

They also assume that software waits for the count to read zero before each start. Only then has the finish flag from an earlier window been cleared in the measured domain.

The stimulus keeps within these assumptions:
- Every measurement goes through a clear, then a poll for zero, then a start.
- Fields are updated only in the start write.
- The slowest source period is three reference cycles, well inside the eight-cycle minimum window.

The sweep then covers every source against several window lengths, including clamped windows and saturation.

// File: rtl/fcnt_pkg.sv
`timescale 1ns/1ps
package fcnt_pkg;
  localparam int unsigned CLR_BIT  = 0;
  localparam int unsigned RUN_BIT  = 1;
  localparam int unsigned WEN_BIT  = 2;
  localparam int unsigned SRC_LSB  = 3;
  localparam int unsigned DONE_BIT = 8;
  localparam int unsigned WIN_LSB  = 16;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } fc_state_e;
endpackage

// File: rtl/fcnt_sync.sv
`timescale 1ns/1ps
// Multi-flop level synchronizer; with d_i tied high it serves as a
// reset synchronizer (asynchronous assert, synchronous release).
module fcnt_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;
  logic [STAGES-1:0] ff_d;

  generate
    if (STAGES > 1) begin : g_chain
      always_comb ff_d = {ff_q[STAGES-2:0], d_i};
    end else begin : g_single
      always_comb ff_d = d_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '0;
    else         ff_q <= ff_d;
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/fcnt_ctrl.sv
`timescale 1ns/1ps
// Reference-domain control register, window timer and result capture.
module fcnt_ctrl
  import fcnt_pkg::*;
#(
  parameter int unsigned SEL_W   = 2,
  parameter int unsigned WIN_W   = 16,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned MIN_WIN = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [31:0]      wdata_i,
  input  logic             fin_i,
  input  logic             clr_ack_i,
  input  logic [CNT_W-1:0] meas_cnt_i,
  output logic             clr_o,
  output logic             run_o,
  output logic             gate_o,
  output logic             done_o,
  output logic [SEL_W-1:0] src_o,
  output logic [WIN_W-1:0] win_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [WIN_W-1:0] MIN_W = WIN_W'(MIN_WIN);

  fc_state_e        st_q, st_d;
  logic             clr_q, clr_d, run_q, run_d;
  logic [SEL_W-1:0] src_q, src_d;
  logic [WIN_W-1:0] win_q, win_d, wcnt_q, wcnt_d, eff_win;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             clr_wr, start_wr;

  // Control register next state
  always_comb begin
    clr_d = clr_q;
    run_d = run_q;
    src_d = src_q;
    win_d = win_q;
    if (wr_i) begin
      clr_d = wdata_i[CLR_BIT];
      run_d = wdata_i[RUN_BIT];
      if (wdata_i[WEN_BIT]) begin
        src_d = wdata_i[SRC_LSB +: SEL_W];
        win_d = wdata_i[WIN_LSB +: WIN_W];
      end
    end
  end

  assign clr_wr   = wr_i && wdata_i[CLR_BIT];
  assign start_wr = wr_i && wdata_i[RUN_BIT] && !wdata_i[CLR_BIT];
  assign eff_win  = (win_d < MIN_W) ? MIN_W : win_d;

  // Window sequencer next state
  always_comb begin
    st_d   = st_q;
    wcnt_d = wcnt_q;
    cnt_d  = cnt_q;
    if (clr_wr) begin
      st_d = ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE: if (start_wr) begin
          st_d   = ST_RUN;
          wcnt_d = eff_win - 1'b1;
        end
        ST_RUN: begin
          if (wcnt_q == '0) st_d = ST_WAIT;
          else              wcnt_d = wcnt_q - 1'b1;
        end
        ST_WAIT: if (fin_i) begin
          st_d  = ST_DONE;
          cnt_d = meas_cnt_i;
        end
        default: ;
      endcase
    end
    if (clr_q && clr_ack_i) cnt_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      clr_q  <= 1'b0;
      run_q  <= 1'b0;
      src_q  <= '0;
      win_q  <= '0;
      wcnt_q <= '0;
      cnt_q  <= '0;
    end else begin
      st_q   <= st_d;
      clr_q  <= clr_d;
      run_q  <= run_d;
      src_q  <= src_d;
      win_q  <= win_d;
      wcnt_q <= wcnt_d;
      cnt_q  <= cnt_d;
    end
  end

  assign clr_o  = clr_q;
  assign run_o  = run_q;
  assign gate_o = (st_q == ST_RUN);
  assign done_o = (st_q == ST_DONE);
  assign src_o  = src_q;
  assign win_o  = win_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/fcnt_meas.sv
`timescale 1ns/1ps
// Measured-domain saturating edge counter with gate and clear synchronizers.
module fcnt_meas #(
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             gate_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             fin_o,
  output logic             clr_s_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             gate_s, clr_s;
  logic             gate_d_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             fin_q, fin_d;

  fcnt_sync #(.STAGES(SYNC_STAGES)) u_gate_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(gate_i), .q_o(gate_s)
  );
  fcnt_sync #(.STAGES(SYNC_STAGES)) u_clr_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(clr_i), .q_o(clr_s)
  );

  always_comb begin
    cnt_d = cnt_q;
    fin_d = fin_q;
    if (clr_s) begin
      cnt_d = '0;
      fin_d = 1'b0;
    end else begin
      if (gate_s && (cnt_q != CNT_MAX)) cnt_d = cnt_q + 1'b1;
      if (gate_d_q && !gate_s)          fin_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_d_q <= 1'b0;
      cnt_q    <= '0;
      fin_q    <= 1'b0;
    end else begin
      gate_d_q <= gate_s;
      cnt_q    <= cnt_d;
      fin_q    <= fin_d;
    end
  end

  assign cnt_o   = cnt_q;
  assign fin_o   = fin_q;
  assign clr_s_o = clr_s;
endmodule

// File: rtl/freq_counter.sv
`timescale 1ns/1ps
module freq_counter
  import fcnt_pkg::*;
#(
  parameter int unsigned SRC_N       = 4,
  parameter int unsigned WIN_W       = 16,
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned MIN_WIN     = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             ref_clk_i,
  input  logic             rst_ni,
  input  logic [SRC_N-1:0] src_clk_i,
  input  logic             wr_i,
  input  logic [31:0]      wdata_i,
  input  logic             raddr_i,
  output logic [31:0]      rdata_o,
  output logic             done_o
);
  localparam int unsigned SEL_W = (SRC_N > 1) ? $clog2(SRC_N) : 1;

  logic             ref_rst_n, meas_rst_n, meas_clk;
  logic             clr_q, run_q, gate, done;
  logic [SEL_W-1:0] src_q;
  logic [WIN_W-1:0] win_q;
  logic [CNT_W-1:0] cnt_q, meas_cnt;
  logic             meas_fin, meas_clr_s, fin_ref, clr_ack_ref;
  logic [31:0]      ctrl_word;

  fcnt_sync #(.STAGES(SYNC_STAGES)) u_ref_rst (
    .clk_i(ref_clk_i), .rst_ni(rst_ni), .d_i(1'b1), .q_o(ref_rst_n)
  );

  // Source selection; the index only moves while no window is open.
  assign meas_clk = src_clk_i[src_q];

  fcnt_sync #(.STAGES(SYNC_STAGES)) u_meas_rst (
    .clk_i(meas_clk), .rst_ni(rst_ni), .d_i(1'b1), .q_o(meas_rst_n)
  );

  fcnt_ctrl #(
    .SEL_W(SEL_W), .WIN_W(WIN_W), .CNT_W(CNT_W), .MIN_WIN(MIN_WIN)
  ) u_ctrl (
    .clk_i(ref_clk_i), .rst_ni(ref_rst_n),
    .wr_i(wr_i), .wdata_i(wdata_i),
    .fin_i(fin_ref), .clr_ack_i(clr_ack_ref), .meas_cnt_i(meas_cnt),
    .clr_o(clr_q), .run_o(run_q), .gate_o(gate), .done_o(done),
    .src_o(src_q), .win_o(win_q), .cnt_o(cnt_q)
  );

  fcnt_meas #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_meas (
    .clk_i(meas_clk), .rst_ni(meas_rst_n),
    .gate_i(gate), .clr_i(clr_q),
    .cnt_o(meas_cnt), .fin_o(meas_fin), .clr_s_o(meas_clr_s)
  );

  fcnt_sync #(.STAGES(SYNC_STAGES)) u_fin_sync (
    .clk_i(ref_clk_i), .rst_ni(ref_rst_n), .d_i(meas_fin), .q_o(fin_ref)
  );
  fcnt_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk_i(ref_clk_i), .rst_ni(ref_rst_n), .d_i(meas_clr_s), .q_o(clr_ack_ref)
  );

  always_comb begin
    ctrl_word                      = '0;
    ctrl_word[CLR_BIT]             = clr_q;
    ctrl_word[RUN_BIT]             = run_q;
    ctrl_word[SRC_LSB +: SEL_W]    = src_q;
    ctrl_word[DONE_BIT]            = done;
    ctrl_word[WIN_LSB +: WIN_W]    = win_q;
  end

  assign rdata_o = raddr_i ? 32'(cnt_q) : ctrl_word;
  assign done_o  = done;
endmodule

// File: rtl/fcnt_chk.sv
`timescale 1ns/1ps
module fcnt_chk #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned SEL_W = 2,
  parameter int unsigned WIN_W = 16
) (
  input logic             ref_clk_i,
  input logic             meas_clk_i,
  input logic             rst_ni,
  input logic             wr_i,
  input logic [31:0]      wdata_i,
  input logic             done_i,
  input logic             gate_i,
  input logic [CNT_W-1:0] cnt_q_i,
  input logic [WIN_W-1:0] win_q_i,
  input logic [SEL_W-1:0] src_q_i,
  input logic [CNT_W-1:0] meas_cnt_i,
  input logic             meas_clr_s_i
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  p_clear_drops_done_r2: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i[0]) |=> !done_i);

  p_fields_kept_r3: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (wr_i && !wdata_i[2]) |=> ($stable(win_q_i) && $stable(src_q_i)));

  p_result_held_r7: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (done_i && !(wr_i && wdata_i[0])) |=> (done_i && $stable(cnt_q_i)));

  p_gate_closed_when_done_r7: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    done_i |-> !gate_i);

  p_no_wrap_r8: assert property (@(posedge meas_clk_i) disable iff (!rst_ni)
    ((meas_cnt_i == CNT_MAX) && !meas_clr_s_i) |=> (meas_cnt_i == CNT_MAX));
endmodule

bind freq_counter fcnt_chk #(.CNT_W(CNT_W), .SEL_W(SEL_W), .WIN_W(WIN_W)) chk_i (
  .ref_clk_i(ref_clk_i), .meas_clk_i(meas_clk), .rst_ni(rst_ni),
  .wr_i(wr_i), .wdata_i(wdata_i), .done_i(done), .gate_i(gate),
  .cnt_q_i(cnt_q), .win_q_i(win_q), .src_q_i(src_q),
  .meas_cnt_i(meas_cnt), .meas_clr_s_i(meas_clr_s)
);

// File: tb/freq_counter_tb_top.sv
`timescale 1ns/1ps
module freq_counter_tb_top;
  localparam int unsigned CNT_W = 10;
  localparam int          SAT   = (1 << CNT_W) - 1;

  logic        ref_clk, rst_n, wr, raddr, done;
  logic [3:0]  src_clk;
  logic [31:0] wdata, rdata;
  int          tests = 0;
  int          fails = 0;
  real         per [4] = '{3.0, 5.0, 8.0, 12.0};
  int          wins [4] = '{8, 23, 64, 150};

  freq_counter #(.CNT_W(CNT_W)) dut_i (
    .ref_clk_i(ref_clk), .rst_ni(rst_n), .src_clk_i(src_clk),
    .wr_i(wr), .wdata_i(wdata), .raddr_i(raddr), .rdata_o(rdata), .done_o(done)
  );

  initial begin ref_clk = 0; forever #2 ref_clk = ~ref_clk; end
  initial begin src_clk[0] = 0; forever #1.5 src_clk[0] = ~src_clk[0]; end
  initial begin src_clk[1] = 0; forever #2.5 src_clk[1] = ~src_clk[1]; end
  initial begin src_clk[2] = 0; forever #4   src_clk[2] = ~src_clk[2]; end
  initial begin src_clk[3] = 0; forever #6   src_clk[3] = ~src_clk[3]; end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic write(input logic [31:0] d);
    @(negedge ref_clk); wr = 1'b1; wdata = d;
    @(negedge ref_clk); wr = 1'b0; wdata = '0;
  endtask

  task automatic read(input logic a, output logic [31:0] v);
    raddr = a; #1; v = rdata;
  endtask

  function automatic logic [31:0] start_word(input int src, input int win);
    return (32'(win) << 16) | (32'(src) << 3) | 32'h6;
  endfunction

  task automatic clear_and_poll();
    logic [31:0] v;
    write(32'h1);
    check(done == 1'b0, "R2 done after clear", longint'(done), 0);
    v = 32'hFFFF_FFFF;
    for (int i = 0; i < 40; i++) begin
      read(1'b1, v);
      if (v == 0) break;
      @(negedge ref_clk);
    end
    check(v == 0, "R2 count cleared", longint'(v), 0);
  endtask

  task automatic measure(input int src, input int win, output logic [31:0] cnt);
    clear_and_poll();
    write(start_word(src, win));
    for (int i = 0; i < 5000; i++) begin
      if (done) break;
      @(negedge ref_clk);
    end
    check(done == 1'b1, "R7 done raised", longint'(done), 1);
    read(1'b1, cnt);
  endtask

  task automatic check_near(input string tag, input logic [31:0] act, input real exp);
    real d;
    d = real'(act) - exp;
    if (d < 0.0) d = -d;
    check(d <= 2.0, tag, longint'(act), longint'($rtoi(exp)));
  endtask

  initial begin
    logic [31:0] v, c, held;
    rst_n = 0; wr = 0; wdata = '0; raddr = 0;
    repeat (5) @(negedge ref_clk);
    rst_n = 1;
    repeat (6) @(negedge ref_clk);

    read(1'b0, v); check(v == 0, "R1 control after reset", longint'(v), 0);
    read(1'b1, v); check(v == 0, "R1 count after reset", longint'(v), 0);
    check(done == 1'b0, "R1 done after reset", longint'(done), 0);

    // R4 / R5: every source against several windows
    for (int s = 0; s < 4; s++) begin
      for (int w = 0; w < 4; w++) begin
        measure(s, wins[w], c);
        check_near($sformatf("R4 R5 src%0d win%0d", s, wins[w]), c, wins[w] * 4.0 / per[s]);
      end
    end

    // R9: control word layout after a completed measurement
    measure(2, 64, c);
    read(1'b0, v);
    check(v == ((32'd64 << 16) | 32'h100 | (32'd2 << 3) | 32'h2), "R9 control layout",
          longint'(v), longint'((32'd64 << 16) | 32'h100 | (32'd2 << 3) | 32'h2));
    check(v[8] == 1'b1, "R7 done bit in control", longint'(v[8]), 1);

    // R7: start while done is ignored, count holds
    held = c;
    write(start_word(0, 150));
    repeat (300) @(negedge ref_clk);
    read(1'b1, v);
    check(v == held, "R7 count holds", longint'(v), longint'(held));
    check(done == 1'b1, "R7 done stays", longint'(done), 1);

    // R3: field-update bit clear keeps fields
    write((32'd999 << 16) | (32'd1 << 3));
    read(1'b0, v);
    check(v[31:16] == 16'd150 && v[4:3] == 2'd0, "R3 fields kept",
          longint'(v[31:16]), 150);
    check(v[1:0] == 2'b00, "R3 run/clear follow write", longint'(v[1:0]), 0);
    write((32'd7 << 16) | (32'd3 << 3) | 32'h1);
    read(1'b0, v);
    check(v[31:16] == 16'd150 && v[4:3] == 2'd0 && v[0] == 1'b1, "R3 clear with fields kept",
          longint'(v[31:16]), 150);

    // R6: short windows clamp to the minimum
    measure(1, 2, c);
    check_near("R6 window 2 clamps", c, 8 * 4.0 / 5.0);
    measure(1, 0, c);
    check_near("R6 window 0 clamps", c, 8 * 4.0 / 5.0);

    // R8: saturation
    measure(0, 1000, c);
    check(c == 32'(SAT), "R8 saturates", longint'(c), longint'(SAT));

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge ref_clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual hang expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule